// File: doc/BRIEF.md
# Serial-to-Parallel Character Display Command Latch

This block is the receiving end of a serial link that drives a character display controller over its parallel bus. A host acting as SPI master pulls an active-low select low and clocks a 16-bit word into the block, most significant bit first, one bit per serial clock. When the select returns high, the block checks that exactly sixteen bits arrived. A complete word is copied onto the display-side pins in a single step: the low byte goes to the data bus, two bits of the high byte go to register select and read/write, and the rest of the high byte goes to spare control outputs. The block then produces one enable strobe so the display controller executes the command or stores the character exactly once.

All serial inputs are resynchronised into the system clock domain, and bits are taken on detected rising edges of the serial clock. A busy output covers the strobe and a programmable hold-off after it, so the host can pace its words. Frames of the wrong length, and frames that end while busy is high, leave the display pins untouched. The display bus is a plain level-and-strobe bus with no back-pressure, so the only pacing signal is busy. Reading the display busy flag back over the serial link is not supported.

Top module: `lcd_spi_latch`

## Requirements
- R1: After reset, lcd_data, lcd_rs, lcd_rw, lcd_aux, lcd_en and busy are all 0.
- R2: While spi_sel_n is low, each detected rising edge of spi_sclk shifts one bit of spi_mosi into a 16-bit word, first bit received becoming bit 15. Bits 7..0 of a committed word appear on lcd_data.
- R3: On commit, bit 9 of the word drives lcd_rs, bit 8 drives lcd_rw, and bits 15..10 drive lcd_aux[5:0]. Word 0x0001 gives rs=0, rw=0, data=0x01; word 0x0200 OR a character code gives rs=1, rw=0 and the code on lcd_data.
- R4: The display outputs change only on a commit, which follows a low-to-high transition of spi_sel_n. While the select is still low after sixteen bits, the outputs keep their previous values.
- R5: A frame with fewer or more than 16 rising serial clock edges is discarded: no enable pulse, outputs unchanged.
- R6: Serial clock and data activity while spi_sel_n is high has no effect on any output.
- R7: Each commit produces exactly one lcd_en pulse, EN_CYCLES system clocks wide. It rises in the same cycle that the outputs take the new word, within 10 cycles of the select rising.
- R8: busy rises with lcd_en and stays high for EN_CYCLES + HOLD_CYCLES system clocks in total.
- R9: A valid frame whose select rises while busy is high is discarded: no enable pulse, outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master (idle low) |
| spi_sel_n | input | 1 | Active-low frame select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| lcd_data | output | 8 | Display data bus |
| lcd_rs | output | 1 | Display register select (0 instruction, 1 data) |
| lcd_rw | output | 1 | Display read/write line |
| lcd_aux | output | 6 | Remaining high-byte control bits |
| lcd_en | output | 1 | Enable strobe to the display controller |
| busy | output | 1 | High during the strobe and the hold-off after it |

## Verification
A bit counter that drifts would show up on the first frame after it: either a good frame gives no strobe, or a short or long frame changes the display pins within a few cycles of the select rising. A shift register that slips a position shows a data byte or control bit moved by one place on the next strobe. A wrong strobe counter shows a wrong enable width or busy length within EN_CYCLES + HOLD_CYCLES cycles. A lost busy state shows as a second strobe inside the hold-off window.

// File: rtl/lcdspi_pkg.sv
package lcdspi_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 8;
  localparam int AUX_W  = WORD_W - DATA_W - 2;

  // field order matters: rs at bit 9, rw at bit 8, data at 7..0
  typedef struct packed {
    logic [AUX_W-1:0]  aux;
    logic              rs;
    logic              rw;
    logic [DATA_W-1:0] data;
  } lcd_word_t;
endpackage

// File: rtl/lcdspi_sync.sv
module lcdspi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/lcdspi_shift.sv
module lcdspi_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sel_n,
  input  logic              mosi,
  output logic              commit,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);

  logic             sclk_d, sel_d;
  logic [CNT_W-1:0] cnt;
  logic             sclk_rise, sel_rise, sel_fall;

  assign sclk_rise = sclk & ~sclk_d;
  assign sel_rise  = sel_n & ~sel_d;
  assign sel_fall  = ~sel_n & sel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sel_d  <= 1'b1;
      cnt    <= '0;
      word   <= '0;
      commit <= 1'b0;
    end else begin
      sclk_d <= sclk;
      sel_d  <= sel_n;
      commit <= sel_rise && (cnt == CNT_FULL);
      if (sel_fall) begin
        cnt <= '0;
      end else if (!sel_n && sclk_rise) begin
        word <= {word[WORD_W-2:0], mosi};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcdspi_strobe.sv
module lcdspi_strobe #(
  parameter int EN_CYCLES = 8,
  parameter int HOLD_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic en,
  output logic busy
);
  localparam int TOTAL = EN_CYCLES + HOLD_CYCLES;
  localparam int CW = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt, nxt;

  assign accept = start && (cnt == '0);

  always_comb begin
    if (accept)          nxt = CW'(TOTAL);
    else if (cnt != '0)  nxt = cnt - 1'b1;
    else                 nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      en   <= 1'b0;
      busy <= 1'b0;
    end else begin
      cnt  <= nxt;
      en   <= nxt > CW'(HOLD_CYCLES);
      busy <= nxt != '0;
    end
  end
endmodule

// File: rtl/lcd_spi_latch.sv
module lcd_spi_latch
  import lcdspi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EN_CYCLES = 8,
  parameter int HOLD_CYCLES = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_sel_n,
  input  logic             spi_mosi,
  output logic [DATA_W-1:0] lcd_data,
  output logic             lcd_rs,
  output logic             lcd_rw,
  output logic [AUX_W-1:0] lcd_aux,
  output logic             lcd_en,
  output logic             busy
);
  logic [2:0]        sync_q;
  logic              commit, accept;
  logic [WORD_W-1:0] shift_word;
  lcd_word_t         out_q;

  // order: {sclk, sel_n, mosi}; select resets to idle-high
  lcdspi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_sel_n, spi_mosi}),
    .q(sync_q)
  );

  lcdspi_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk(sync_q[2]), .sel_n(sync_q[1]), .mosi(sync_q[0]),
    .commit(commit), .word(shift_word)
  );

  lcdspi_strobe #(.EN_CYCLES(EN_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)) u_strobe (
    .clk(clk), .rst_n(rst_n),
    .start(commit), .accept(accept),
    .en(lcd_en), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (accept) out_q <= lcd_word_t'(shift_word);
  end

  assign lcd_data = out_q.data;
  assign lcd_rs   = out_q.rs;
  assign lcd_rw   = out_q.rw;
  assign lcd_aux  = out_q.aux;
endmodule

// File: rtl/lcdspi_chk.sv
module lcdspi_chk #(
  parameter int EN_CYCLES = 8,
  parameter int HOLD_CYCLES = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] lcd_data,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic [5:0] lcd_aux,
  input logic       lcd_en,
  input logic       busy
);
  localparam int RW = $clog2(EN_CYCLES + 2);
  logic [RW-1:0] en_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_run <= '0;
    else if (lcd_en) en_run <= (en_run == RW'(EN_CYCLES + 1)) ? en_run : en_run + 1'b1;
    else             en_run <= '0;
  end

  AST_OUT_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({lcd_aux, lcd_rs, lcd_rw, lcd_data}) |-> $rose(lcd_en)); // R4
  AST_EN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en) |-> en_run == RW'(EN_CYCLES)); // R7
  AST_EN_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> busy); // R8
  AST_BUSY_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !lcd_en && !$past(lcd_en)); // R8
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> !$past(busy)); // R9
endmodule

bind lcd_spi_latch lcdspi_chk #(.EN_CYCLES(EN_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lcd_data(lcd_data), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
  .lcd_aux(lcd_aux), .lcd_en(lcd_en), .busy(busy)
);

// File: tb/lcd_spi_latch_tb.sv
module lcd_spi_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EN_C = 6;
  localparam int HOLD_C = 120;

  logic clk = 0, rst_n = 0, sclk = 0, sel_n = 1, mosi = 0;
  logic [7:0] lcd_data;
  logic       lcd_rs, lcd_rw, lcd_en, busy;
  logic [5:0] lcd_aux;
  int total = 0, bad = 0;
  logic [15:0] last_word = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_spi_latch #(.SYNC_STAGES(2), .EN_CYCLES(EN_C), .HOLD_CYCLES(HOLD_C)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_sel_n(sel_n), .spi_mosi(mosi),
    .lcd_data(lcd_data), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_aux(lcd_aux),
    .lcd_en(lcd_en), .busy(busy)
  );

  function automatic logic [15:0] pins();
    return {lcd_aux, lcd_rs, lcd_rw, lcd_data};
  endfunction

  // expected pin image for a word: aux=15..10, rs=9, rw=8, data=7..0
  function automatic logic [15:0] expect_pins(logic [15:0] w);
    return {w[15:10], w[9], w[8], w[7:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bits(logic [31:0] w, int nbits, int half);
    @(negedge clk); sel_n = 0;
    repeat (half) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[nbits-1-i];
      repeat (half) @(negedge clk);
      sclk = 1;
      repeat (half) @(negedge clk);
      sclk = 0;
    end
    repeat (half) @(negedge clk);
  endtask

  task automatic raise_sel();
    sel_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_commit(logic [15:0] w, string req);
    int n = 0;
    int waited = 0;
    while (lcd_en !== 1'b1 && waited < 10) begin @(negedge clk); waited++; end
    chk({req, " strobe seen"}, lcd_en, 1);
    chk({req, " pins"}, pins(), expect_pins(w));
    chk("R8 busy with strobe", busy, 1);
    while (lcd_en === 1'b1) begin n++; @(negedge clk); end
    chk("R7 strobe width", n, EN_C);
    chk("R8 busy after strobe", busy, 1);
    last_word = w;
  endtask

  task automatic wait_idle(bit measure);
    int n = 0;
    while (busy === 1'b1) begin n++; @(negedge clk); end
    if (measure) chk("R8 hold-off length", n, HOLD_C);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_none(string req);
    logic seen = 0;
    repeat (15) begin @(negedge clk); if (lcd_en) seen = 1; end
    chk({req, " no strobe"}, seen, 0);
    chk({req, " pins kept"}, pins(), expect_pins(last_word));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset pins", pins(), 16'h0000);
    chk("R1 reset en", lcd_en, 0);
    chk("R1 reset busy", busy, 0);

    // clear-display style instruction
    shift_bits(32'h0001, 16, 3); raise_sel();
    check_commit(16'h0001, "R3 instruction");
    chk("R3 rs low", lcd_rs, 0);
    wait_idle(1);

    // character write
    shift_bits(32'h0241, 16, 2); raise_sel();
    check_commit(16'h0241, "R3 data write");
    chk("R3 rs high", lcd_rs, 1);
    wait_idle(1);

    // sixteen bits in, select still low: nothing yet
    shift_bits(32'hA5C3, 16, 2);
    chk("R4 pins before sel rise", pins(), expect_pins(last_word));
    chk("R4 no strobe before sel rise", lcd_en, 0);
    raise_sel();
    check_commit(16'hA5C3, "R4 commit on sel rise");
    wait_idle(0);

    // random words, random serial rates
    for (int k = 0; k < 20; k++) begin
      w = 16'($urandom);
      shift_bits({16'h0, w}, 16, 2 + int'($urandom % 3)); raise_sel();
      check_commit(w, "R2 random word");
      wait_idle(0);
    end

    // short and long frames
    shift_bits(32'h3FF, 10, 2); raise_sel();
    check_none("R5 short frame");
    shift_bits(32'h1FFFF, 17, 2); raise_sel();
    check_none("R5 long frame");
    shift_bits(32'h0, 0, 2); raise_sel();
    check_none("R5 empty frame");

    // serial activity with select high
    for (int i = 0; i < 20; i++) begin
      mosi = $urandom % 2;
      repeat (2) @(negedge clk); sclk = 1;
      repeat (2) @(negedge clk); sclk = 0;
    end
    check_none("R6 sclk while deselected");
    shift_bits(32'h5A3C, 16, 2); raise_sel();
    check_commit(16'h5A3C, "R6 next frame clean");
    wait_idle(0);

    // frame ending while busy
    shift_bits(32'h0301, 16, 2); raise_sel();
    check_commit(16'h0301, "R9 first frame");
    shift_bits(32'hFFFF, 16, 2); raise_sel();
    chk("R9 still busy at second commit", busy, 1);
    check_none("R9 frame during busy");
    wait_idle(0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule